// File: doc/BRIEF.md
# SPI NOR Flash Command Monitor

This block watches traffic on a serial NOR flash bus after the bit-level shifting has already been done elsewhere. For every transferred byte it receives one strobe carrying the byte the host drove and the byte the flash returned. A separate pulse marks any change on the chip-select line. The monitor works out which flash command is running and where each byte sits inside it: opcode, address, dummy, identification or streaming data. It then issues one decoded event record for each byte that carries meaning.

Events come out in input order, one clock after the stimulus that caused them, and nothing can stall them. Each record carries an event kind, the opcode of the command it belongs to, and a 24-bit value field. Every supported opcode is a parameter. Sector-erase addresses that do not fall on a 4 KiB boundary are flagged, and so are opcodes outside the supported set.

Top module: `spinor_cmd_monitor`

## Requirements
- R1: Every event appears on `evt_vld` exactly one clock after the strobe or chip-select pulse that caused it. A cycle with neither input gives no event in the next cycle. Kind codes are: 1 command, 2 address, 3 identification, 4 status, 5 data, 6 end of data block, 7 unknown opcode, 8 misaligned erase.
- R2: A `cs_evt` pulse returns the parser to idle from any state. If data bytes were reported since the last command started, it emits kind 6 with `evt_op` set to that command's opcode and `evt_val` set to the number of data bytes. When `cs_evt` and `byte_vld` are high in the same cycle, the byte is dropped.
- R3: In idle, the MOSI byte is taken as an opcode. A supported opcode gives kind 1 with value 0. Any other byte gives kind 7 with `evt_op` and `evt_val[7:0]` equal to the byte, and the parser stays idle.
- R4: Write-enable (default 0x06) is complete after its opcode. The next byte is decoded as a new opcode.
- R5: For read (default 0x03), bytes 2, 3 and 4 on MOSI form a 24-bit address, most significant byte first, reported as kind 2 on byte 4. Each later byte gives kind 5 with `evt_val[7:0]` set to the MISO byte and `evt_val[23:8]` set to its 0-based index in the block.
- R6: Fast read (default 0x0B) works like read, except that byte 5 is a dummy and gives no event. Data starts at byte 6.
- R7: Page program (default 0x02) reports the address like read. Its data events take the byte from MOSI.
- R8: Sector erase (default 0x20) collects its address from bytes 2 to 4. On byte 4 it emits kind 2 when address bits [11:0] are zero, otherwise kind 8 carrying the address. The parser then returns to idle.
- R9: Read-ID (default 0x9F) reports MISO bytes 2, 3 and 4 as kind 3, with `evt_val[9:8]` set to 0 (manufacturer), 1 (memory type) and 2 (device). It then returns to idle.
- R10: Read-status (default 0x05) reports every MISO byte after the opcode as kind 4, with the byte in `evt_val[7:0]` and zeros above it, until chip select changes.
- R11: Electronic-ID read (default 0x90) reports no event for bytes 2 to 4. A MOSI byte 4 equal to 0x00 selects manufacturer first; any other value selects device first. Bytes 5 and 6 give kind 3, with selector 0 for manufacturer and 2 for device, in the chosen order. The parser then returns to idle.
- R12: While the synchronous reset is held, and in the cycle after it is released, `evt_vld` is low and the parser is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | One transferred byte pair is present |
| mosi_byte | input | 8 | Byte driven by the host |
| miso_byte | input | 8 | Byte returned by the flash |
| cs_evt | input | 1 | Chip-select edge seen |
| evt_vld | output | 1 | Event record valid |
| evt_kind | output | 4 | Event kind code |
| evt_op | output | 8 | Opcode the event belongs to |
| evt_val | output | 24 | Address, byte, count or ID field |

## Verification
The assertions check, on every cycle, properties that hold regardless of the command in flight. Idle inputs give no event, and a chip-select pulse can yield only an end-of-block event. Kind codes stay in range, unknown-opcode events echo the byte that caused them, and erase addresses agree with the kind they were given. Only the bench scenarios can show the byte-position behaviour that depends on history. That covers where address collection ends, dummy bytes producing nothing, data indices counting up, the two ID reply orders, the block byte count, and returning to idle after fixed-length commands in the middle of a chip-select window.

// File: rtl/spinor_mon_pkg.sv
package spinor_mon_pkg;

  localparam int VAL_W    = 24;
  localparam int NUM_CMDS = 8;

  typedef enum logic [3:0] {
    EV_NONE    = 4'd0,
    EV_CMD     = 4'd1,
    EV_ADDR    = 4'd2,
    EV_ID      = 4'd3,
    EV_STATUS  = 4'd4,
    EV_DATA    = 4'd5,
    EV_BLKEND  = 4'd6,
    EV_UNKNOWN = 4'd7,
    EV_ALIGN   = 4'd8
  } evt_kind_e;

  // index order matches the opcode table in the decoder (entry i -> value i+1)
  typedef enum logic [3:0] {
    C_IDLE = 4'd0,
    C_WREN = 4'd1,
    C_RDID = 4'd2,
    C_RDSR = 4'd3,
    C_READ = 4'd4,
    C_FAST = 4'd5,
    C_SE   = 4'd6,
    C_PP   = 4'd7,
    C_REMS = 4'd8
  } cmd_e;

  typedef struct packed {
    logic             vld;
    evt_kind_e        kind;
    logic [7:0]       op;
    logic [VAL_W-1:0] val;
  } evt_t;

endpackage

// File: rtl/spinor_op_decode.sv
module spinor_op_decode
  import spinor_mon_pkg::*;
#(
  parameter logic [7:0] OP_WREN = 8'h06,
  parameter logic [7:0] OP_RDID = 8'h9F,
  parameter logic [7:0] OP_RDSR = 8'h05,
  parameter logic [7:0] OP_READ = 8'h03,
  parameter logic [7:0] OP_FAST = 8'h0B,
  parameter logic [7:0] OP_SE   = 8'h20,
  parameter logic [7:0] OP_PP   = 8'h02,
  parameter logic [7:0] OP_REMS = 8'h90
) (
  input  logic [7:0] opcode,
  output logic       hit,
  output cmd_e       cmd
);

  localparam logic [7:0] OPS [NUM_CMDS] = '{
    OP_WREN, OP_RDID, OP_RDSR, OP_READ, OP_FAST, OP_SE, OP_PP, OP_REMS
  };

  logic [NUM_CMDS-1:0] match;

  for (genvar gi = 0; gi < NUM_CMDS; gi++) begin : g_cmp
    assign match[gi] = (opcode == OPS[gi]);
  end

  // lowest table index wins if two parameters collide
  always_comb begin
    hit = 1'b0;
    cmd = C_IDLE;
    for (int i = 0; i < NUM_CMDS; i++) begin
      if (match[i] && !hit) begin
        hit = 1'b1;
        cmd = cmd_e'(i + 1);
      end
    end
  end

endmodule

// File: rtl/spinor_mon_seq.sv
module spinor_mon_seq
  import spinor_mon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_vld,
  input  logic [7:0] mosi_byte,
  input  logic [7:0] miso_byte,
  input  logic       cs_evt,
  input  logic       dec_hit,
  input  cmd_e       dec_cmd,
  output evt_t       evt_nxt
);

  localparam int POS_W   = 3;
  localparam int IDX_W   = POS_W + 1;
  localparam int DIDX_W  = VAL_W - 8;
  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  cmd_e             cmd_q, cmd_n;
  logic [POS_W-1:0] pos_q, pos_n;
  logic [7:0]       op_q, op_n;
  logic [23:0]      addr_q, addr_n;
  logic             ord_q, ord_n;
  logic             open_q, open_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] data_start;
  logic [23:0]      addr_sh;

  assign idx        = {1'b0, pos_q} + IDX_W'(1);
  assign data_start = (cmd_q == C_FAST) ? IDX_W'(6) : IDX_W'(5);
  assign addr_sh    = {addr_q[15:0], mosi_byte};

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= C_IDLE;
      pos_q  <= '0;
      op_q   <= '0;
      addr_q <= '0;
      ord_q  <= 1'b0;
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cmd_q  <= cmd_n;
      pos_q  <= pos_n;
      op_q   <= op_n;
      addr_q <= addr_n;
      ord_q  <= ord_n;
      open_q <= open_n;
      cnt_q  <= cnt_n;
    end
  end

  always_comb begin
    cmd_n   = cmd_q;
    pos_n   = pos_q;
    op_n    = op_q;
    addr_n  = addr_q;
    ord_n   = ord_q;
    open_n  = open_q;
    cnt_n   = cnt_q;
    evt_nxt = '0;

    if (cs_evt) begin
      if (open_q) begin
        evt_nxt.vld  = 1'b1;
        evt_nxt.kind = EV_BLKEND;
        evt_nxt.op   = op_q;
        evt_nxt.val  = VAL_W'(cnt_q);
      end
      cmd_n  = C_IDLE;
      pos_n  = '0;
      addr_n = '0;
      open_n = 1'b0;
      cnt_n  = '0;
    end else if (byte_vld) begin
      if (cmd_q != C_IDLE && pos_q != POS_MAX) pos_n = pos_q + POS_W'(1);
      evt_nxt.op = op_q;
      unique case (cmd_q)
        C_IDLE: begin
          evt_nxt.vld = 1'b1;
          evt_nxt.op  = mosi_byte;
          if (dec_hit) begin
            evt_nxt.kind = EV_CMD;
            op_n         = mosi_byte;
            open_n       = 1'b0;
            cnt_n        = '0;
            if (dec_cmd != C_WREN) begin
              cmd_n = dec_cmd;
              pos_n = POS_W'(1);
            end
          end else begin
            evt_nxt.kind = EV_UNKNOWN;
            evt_nxt.val  = {16'h0, mosi_byte};
          end
        end
        C_READ, C_FAST, C_PP, C_SE: begin
          if (idx >= IDX_W'(2) && idx <= IDX_W'(4)) begin
            addr_n = addr_sh;
            if (idx == IDX_W'(4)) begin
              evt_nxt.vld = 1'b1;
              evt_nxt.val = addr_sh;
              if (cmd_q == C_SE) begin
                evt_nxt.kind = (addr_sh[11:0] != 12'h0) ? EV_ALIGN : EV_ADDR;
                cmd_n        = C_IDLE;
                pos_n        = '0;
              end else begin
                evt_nxt.kind = EV_ADDR;
              end
            end
          end else if (idx >= data_start) begin
            evt_nxt.vld  = 1'b1;
            evt_nxt.kind = EV_DATA;
            evt_nxt.val  = {DIDX_W'(cnt_q), (cmd_q == C_PP) ? mosi_byte : miso_byte};
            open_n       = 1'b1;
            if (cnt_q != CNT_MAX) cnt_n = cnt_q + CNT_W'(1);
          end
        end
        C_RDID: begin
          evt_nxt.vld  = 1'b1;
          evt_nxt.kind = EV_ID;
          evt_nxt.val  = {14'h0, 2'(idx - IDX_W'(2)), miso_byte};
          if (idx == IDX_W'(4)) begin
            cmd_n = C_IDLE;
            pos_n = '0;
          end
        end
        C_RDSR: begin
          evt_nxt.vld  = 1'b1;
          evt_nxt.kind = EV_STATUS;
          evt_nxt.val  = {16'h0, miso_byte};
        end
        C_REMS: begin
          if (idx == IDX_W'(4)) begin
            ord_n = (mosi_byte != 8'h00);
          end else if (idx == IDX_W'(5) || idx == IDX_W'(6)) begin
            evt_nxt.vld  = 1'b1;
            evt_nxt.kind = EV_ID;
            // selector 2 = device, 0 = manufacturer; order flips with ord_q
            evt_nxt.val  = {14'h0, ((idx == IDX_W'(5)) ^ ord_q) ? 2'd0 : 2'd2, miso_byte};
            if (idx == IDX_W'(6)) begin
              cmd_n = C_IDLE;
              pos_n = '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/spinor_evt_reg.sv
module spinor_evt_reg
  import spinor_mon_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  evt_t evt_in,
  output evt_t evt_out
);

  always_ff @(posedge clk) begin
    if (rst) evt_out <= '0;
    else     evt_out <= evt_in;
  end

endmodule

// File: rtl/spinor_cmd_monitor.sv
module spinor_cmd_monitor
  import spinor_mon_pkg::*;
#(
  parameter logic [7:0] OP_WREN = 8'h06,
  parameter logic [7:0] OP_RDID = 8'h9F,
  parameter logic [7:0] OP_RDSR = 8'h05,
  parameter logic [7:0] OP_READ = 8'h03,
  parameter logic [7:0] OP_FAST = 8'h0B,
  parameter logic [7:0] OP_SE   = 8'h20,
  parameter logic [7:0] OP_PP   = 8'h02,
  parameter logic [7:0] OP_REMS = 8'h90,
  parameter int         CNT_W   = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        byte_vld,
  input  logic [7:0]  mosi_byte,
  input  logic [7:0]  miso_byte,
  input  logic        cs_evt,
  output logic        evt_vld,
  output logic [3:0]  evt_kind,
  output logic [7:0]  evt_op,
  output logic [23:0] evt_val
);

  logic dec_hit;
  cmd_e dec_cmd;
  evt_t evt_nxt;
  evt_t evt_q;

  spinor_op_decode #(
    .OP_WREN(OP_WREN), .OP_RDID(OP_RDID), .OP_RDSR(OP_RDSR), .OP_READ(OP_READ),
    .OP_FAST(OP_FAST), .OP_SE(OP_SE), .OP_PP(OP_PP), .OP_REMS(OP_REMS)
  ) u_dec (
    .opcode (mosi_byte),
    .hit    (dec_hit),
    .cmd    (dec_cmd)
  );

  spinor_mon_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .byte_vld  (byte_vld),
    .mosi_byte (mosi_byte),
    .miso_byte (miso_byte),
    .cs_evt    (cs_evt),
    .dec_hit   (dec_hit),
    .dec_cmd   (dec_cmd),
    .evt_nxt   (evt_nxt)
  );

  spinor_evt_reg u_out (
    .clk     (clk),
    .rst     (rst),
    .evt_in  (evt_nxt),
    .evt_out (evt_q)
  );

  assign evt_vld  = evt_q.vld;
  assign evt_kind = evt_q.kind;
  assign evt_op   = evt_q.op;
  assign evt_val  = evt_q.val;

endmodule

// File: rtl/spinor_mon_chk.sv
module spinor_mon_chk #(
  parameter logic [7:0] OP_SE = 8'h20
) (
  input logic        clk,
  input logic        rst,
  input logic        byte_vld,
  input logic [7:0]  mosi_byte,
  input logic        cs_evt,
  input logic        evt_vld,
  input logic [3:0]  evt_kind,
  input logic [7:0]  evt_op,
  input logic [23:0] evt_val
);

  AST_QUIET_WITHOUT_INPUT: assert property (@(posedge clk) disable iff (rst)
    (!byte_vld && !cs_evt) |=> !evt_vld); // R1

  AST_KIND_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    evt_vld |-> (evt_kind >= 4'd1 && evt_kind <= 4'd8)); // R1

  AST_CS_ONLY_BLOCK_END: assert property (@(posedge clk) disable iff (rst)
    cs_evt |=> (!evt_vld || evt_kind == 4'd6)); // R2

  AST_UNKNOWN_ECHO: assert property (@(posedge clk) disable iff (rst)
    byte_vld && !cs_evt |=> ((evt_vld && evt_kind == 4'd7) -> (evt_op == $past(mosi_byte) && evt_val[7:0] == $past(mosi_byte)))); // R3

  AST_ALIGN_WARN_MISALIGNED: assert property (@(posedge clk) disable iff (rst)
    (evt_vld && evt_kind == 4'd8) |-> (evt_val[11:0] != 12'h0 && evt_op == OP_SE)); // R8

  AST_ERASE_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (evt_vld && evt_kind == 4'd2 && evt_op == OP_SE) |-> (evt_val[11:0] == 12'h0)); // R8

  AST_ID_SELECTOR: assert property (@(posedge clk) disable iff (rst)
    (evt_vld && evt_kind == 4'd3) |-> (evt_val[9:8] != 2'd3 && evt_val[23:10] == 14'h0)); // R9

  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (evt_vld && evt_kind == 4'd4) |-> (evt_val[23:8] == 16'h0)); // R10

endmodule

bind spinor_cmd_monitor spinor_mon_chk #(.OP_SE(OP_SE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .byte_vld  (byte_vld),
  .mosi_byte (mosi_byte),
  .cs_evt    (cs_evt),
  .evt_vld   (evt_vld),
  .evt_kind  (evt_kind),
  .evt_op    (evt_op),
  .evt_val   (evt_val)
);

// File: tb/sim_spinor_cmd_monitor.sv
module sim_spinor_cmd_monitor;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDID = 8'h9F;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_FAST = 8'h0B;
  localparam logic [7:0] OP_SE   = 8'h20;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_REMS = 8'h90;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byte_vld = 1'b0;
  logic [7:0]  mosi_byte = 8'h0;
  logic [7:0]  miso_byte = 8'h0;
  logic        cs_evt = 1'b0;
  logic        evt_vld;
  logic [3:0]  evt_kind;
  logic [7:0]  evt_op;
  logic [23:0] evt_val;

  always #5 clk = ~clk;

  spinor_cmd_monitor u0 (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .mosi_byte(mosi_byte),
    .miso_byte(miso_byte), .cs_evt(cs_evt), .evt_vld(evt_vld),
    .evt_kind(evt_kind), .evt_op(evt_op), .evt_val(evt_val)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // expected record for the stimulus applied in the previous cycle
  bit          e_vld = 1'b0;
  logic [3:0]  e_kind = '0;
  logic [7:0]  e_op = '0;
  logic [23:0] e_val = '0;
  string       e_req = "R12";

  // reference model state
  bit          m_busy = 1'b0;
  logic [7:0]  m_op = '0;
  int          m_idx = 0;
  logic [23:0] m_addr = '0;
  bit          m_devfirst = 1'b0;
  bit          m_open = 1'b0;
  int          m_cnt = 0;

  function automatic bit is_known(input logic [7:0] b);
    return b == OP_WREN || b == OP_RDID || b == OP_RDSR || b == OP_READ ||
           b == OP_FAST || b == OP_SE || b == OP_PP || b == OP_REMS;
  endfunction

  task automatic want(input int k, input logic [7:0] op, input logic [23:0] v, input string rq);
    e_vld = 1'b1; e_kind = 4'(k); e_op = op; e_val = v; e_req = rq;
  endtask

  task automatic model(input bit c, input bit v, input logic [7:0] m, input logic [7:0] s);
    e_vld = 1'b0; e_req = "R1";
    if (c) begin
      e_req = "R2";
      if (m_open) want(6, m_op, 24'(m_cnt), "R2");
      m_busy = 0; m_idx = 0; m_open = 0; m_cnt = 0; m_addr = '0;
    end else if (v) begin
      if (!m_busy) begin
        if (is_known(m)) begin
          want(1, m, 24'h0, (m == OP_WREN) ? "R4" : "R3");
          m_op = m; m_idx = 1; m_busy = (m != OP_WREN); m_open = 0; m_cnt = 0;
        end else begin
          want(7, m, {16'h0, m}, "R3");
        end
      end else begin
        m_idx++;
        if (m_op == OP_RDSR) begin
          want(4, m_op, {16'h0, s}, "R10");
        end else if (m_op == OP_RDID) begin
          want(3, m_op, {14'h0, 2'(m_idx - 2), s}, "R9");
          if (m_idx == 4) m_busy = 0;
        end else if (m_op == OP_REMS) begin
          e_req = "R11";
          if (m_idx == 4) m_devfirst = (m != 8'h00);
          else if (m_idx == 5) want(3, m_op, {14'h0, m_devfirst ? 2'd2 : 2'd0, s}, "R11");
          else if (m_idx == 6) begin
            want(3, m_op, {14'h0, m_devfirst ? 2'd0 : 2'd2, s}, "R11");
            m_busy = 0;
          end
        end else if (m_idx <= 4) begin
          m_addr = {m_addr[15:0], m};
          if (m_idx == 4) begin
            if (m_op == OP_SE) begin
              want((m_addr[11:0] == 12'h0) ? 2 : 8, m_op, m_addr, "R8");
              m_busy = 0;
            end else begin
              want(2, m_op, m_addr, (m_op == OP_FAST) ? "R6" : (m_op == OP_PP) ? "R7" : "R5");
            end
          end
        end else if (m_op == OP_FAST && m_idx == 5) begin
          e_req = "R6";
        end else begin
          want(5, m_op, {16'(m_cnt), (m_op == OP_PP) ? m : s},
               (m_op == OP_FAST) ? "R6" : (m_op == OP_PP) ? "R7" : "R5");
          m_cnt++; m_open = 1;
        end
      end
    end
  endtask

  task automatic check_out();
    tests++;
    if (evt_vld !== e_vld ||
        (e_vld && (evt_kind !== e_kind || evt_op !== e_op || evt_val !== e_val))) begin
      fails++;
      $display("FAIL %s: got vld=%0b kind=%0d op=%02h val=%06h, expected vld=%0b kind=%0d op=%02h val=%06h",
               e_req, evt_vld, evt_kind, evt_op, evt_val, e_vld, e_kind, e_op, e_val);
    end
  endtask

  task automatic step(input bit c, input bit v, input logic [7:0] m, input logic [7:0] s);
    @(negedge clk);
    check_out();
    cs_evt = c; byte_vld = v; mosi_byte = m; miso_byte = s;
    model(c, v, m, s);
  endtask

  task automatic bt(input logic [7:0] m, input logic [7:0] s);
    step(1'b0, 1'b1, m, s);
  endtask

  task automatic cs();
    step(1'b1, 1'b0, 8'h0, 8'h0);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 8'h0, 8'h0);
  endtask

  function automatic logic [7:0] pick_op(input int r);
    case (r)
      0: return OP_WREN;
      1: return OP_RDID;
      2: return OP_RDSR;
      3: return OP_READ;
      4: return OP_FAST;
      5: return OP_SE;
      6: return OP_PP;
      7: return OP_REMS;
      default: begin
        logic [7:0] b;
        b = 8'($urandom);
        while (is_known(b)) b = b + 8'h1;
        return b;
      end
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion, expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12: first check sees the reset state
    e_req = "R12";
    idle();

    // R5: read with three data bytes, then block end with count 3 (R2)
    cs(); bt(OP_READ, 8'h00); bt(8'h12, 8'h00); bt(8'h34, 8'h00); bt(8'h56, 8'h00);
    bt(8'h00, 8'hA1); bt(8'h00, 8'hA2); idle(); bt(8'h00, 8'hA3); cs();
    // R6: fast read with dummy byte
    bt(OP_FAST, 8'h0); bt(8'h01, 8'h0); bt(8'h02, 8'h0); bt(8'h03, 8'h0);
    bt(8'hEE, 8'h55); bt(8'h00, 8'h66); cs();
    // R7: page program data from MOSI
    bt(OP_PP, 8'h0); bt(8'hAB, 8'h0); bt(8'hCD, 8'h0); bt(8'hEF, 8'h0);
    bt(8'h77, 8'hFF); cs();
    // R8: aligned then misaligned erase in one select window
    bt(OP_SE, 8'h0); bt(8'h00, 8'h0); bt(8'h10, 8'h0); bt(8'h00, 8'h0);
    bt(OP_SE, 8'h0); bt(8'h00, 8'h0); bt(8'h08, 8'h0); bt(8'h00, 8'h0); cs();
    // R4 then R10: write enable followed by status polling
    bt(OP_WREN, 8'h0); bt(OP_RDSR, 8'h0); bt(8'h0, 8'h03); bt(8'h0, 8'hFC); cs();
    // R9: read ID, then the next byte is a new opcode (R3 unknown)
    bt(OP_RDID, 8'h0); bt(8'h0, 8'hC2); bt(8'h0, 8'h20); bt(8'h0, 8'h17); bt(8'hFF, 8'h0); cs();
    // R11: both reply orders
    bt(OP_REMS, 8'h0); bt(8'h0, 8'h0); bt(8'h0, 8'h0); bt(8'h00, 8'h0); bt(8'h0, 8'hC2); bt(8'h0, 8'h14); cs();
    bt(OP_REMS, 8'h0); bt(8'h0, 8'h0); bt(8'h0, 8'h0); bt(8'h01, 8'h0); bt(8'h0, 8'h14); bt(8'h0, 8'hC2); cs();
    // R2: select change with a simultaneous byte drops the byte
    bt(OP_READ, 8'h0); bt(8'h0, 8'h0); bt(8'h0, 8'h0); bt(8'h0, 8'h0); bt(8'h0, 8'h99);
    step(1'b1, 1'b1, OP_RDSR, 8'h44); bt(8'h42, 8'h0); cs();

    // random transactions
    for (int t = 0; t < 600; t++) begin
      int r;
      int len;
      logic [7:0] op;
      r   = int'($urandom % 10);
      op  = pick_op(r);
      len = 1 + int'($urandom % 10);
      bt(op, 8'($urandom));
      for (int b = 2; b <= len; b++) begin
        logic [7:0] mo;
        mo = 8'($urandom);
        if (op == OP_SE && r == 5 && ($urandom % 2) == 0) begin
          if (b == 3) mo = mo & 8'hF0;
          if (b == 4) mo = 8'h00;
        end
        if (op == OP_REMS && b == 4 && ($urandom % 2) == 0) mo = 8'h00;
        if (($urandom % 4) == 0) idle();
        if (($urandom % 50) == 0) step(1'b1, 1'b1, mo, 8'($urandom));
        else bt(mo, 8'($urandom));
      end
      if (($urandom % 8) != 0) cs();
    end
    idle();
    idle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule